// File: doc/BRIEF.md
# Three-Channel Watchdog Timer with Early Warning

The block holds three independent watchdog channels behind a single-cycle register bus. Each channel has a 32-bit up-counter that moves forward by one on every cycle where the reference tick enable is high. Software may overwrite the counter at any time. Each channel also has a bite threshold and a reset-enable bit. While reset is enabled and the counter is at or above the bite threshold, the channel holds its reset request high. Channel 0 drives a recovery-mode reset request. Channels 1 and 2 together drive the normal system reset request.

Channel 0 also has a bark threshold, which gives an earlier warning. While its interrupt enable is set and its counter is at or above the bark threshold, a sticky status bit sets. The interrupt output is that status bit ANDed with the enable. Software clears the status by writing one to it. Software services a channel by writing zero to its counter before the bite threshold is reached.

Top module: `wdt_multi`

## Requirements
- R1: After reset, every counter, threshold and control register reads 0, and the recovery reset, system reset and interrupt outputs are all low.
- R2: Word offsets, with the low two address bits zero, map as follows. Channel n uses base 0x10*n. At that base, +0x0 is the counter, +0x4 is bite, +0x8 is bark (channel 0 only) and +0xC is control. Control bit 0 is interrupt enable, bit 1 is interrupt status and bit 2 is reset enable. Channels 1 and 2 read 0 in control bits 0 and 1. A read of any other offset returns 0, and a write to it has no effect. Read data appears in the same cycle as the read request and is 0 when no read is requested.
- R3: On each clock edge with the tick high and no counter write, a channel's counter increases by one, and it wraps from 0xFFFFFFFF to 0. Without a tick the counter holds.
- R4: A bus write to a counter in the same cycle as a tick loads the written value, and the increment is lost.
- R5: The recovery reset output is high exactly when channel 0 has reset enable set and its counter is greater than or equal to its bite threshold. The system reset output applies the same rule to channels 1 and 2, ORed together. Both outputs are combinational from the registered state.
- R6: On a clock edge where channel 0 has interrupt enable set and its counter is greater than or equal to its bark threshold, the status bit sets. A set wins over a clear in the same edge. The interrupt output equals status AND interrupt enable.
- R7: Writing control with bit 1 high clears the status, and writing it with bit 1 low leaves the status unchanged. Once set, the status stays set even if the counter is rewritten below the bark threshold.
- R8: A bite threshold of 0 with a counter of 0 and reset enable set raises the reset request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick enable, advances all counters |
| bus_valid_i | input | 1 | Bus request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| rst_recovery_o | output | 1 | Recovery-mode reset request from channel 0 |
| rst_system_o | output | 1 | Normal reset request from channel 1 or 2 |
| irq_o | output | 1 | Bark interrupt from channel 0 |

## Verification
Two events can fall on the same edge. A counter write can coincide with a tick, and a status clear can coincide with a live bark condition. The random stimulus drives ticks on about half of all cycles, independent of the bus, so both collisions occur often. Directed cases also force each collision on purpose. The result is judged by reading the counter back and by watching the status and interrupt on the next cycle, against a bench model in which the write wins and the set wins.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned N_CH = 3;
  typedef enum logic [1:0] {
    REG_CUR  = 2'd0,
    REG_BITE = 2'd1,
    REG_BARK = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;
  localparam int unsigned CTRL_IEN = 0;
  localparam int unsigned CTRL_STS = 1;
  localparam int unsigned CTRL_REN = 2;
endpackage

// File: rtl/wdt_channel.sv
module wdt_channel #(
  parameter int unsigned DW       = 32,
  parameter bit          HAS_BARK = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_cur_i,
  input  logic          wr_bite_i,
  input  logic          wr_bark_i,
  input  logic          wr_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cur_o,
  output logic [DW-1:0] bite_o,
  output logic [DW-1:0] bark_o,
  output logic [2:0]    ctrl_o,
  output logic          rst_req_o,
  output logic          irq_o
);
  import wdt_pkg::*;

  logic [DW-1:0] cur_q, bite_q;
  logic          ren_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      bite_q <= '0;
      ren_q  <= 1'b0;
    end else begin
      if (wr_cur_i)    cur_q <= wdata_i;   // write beats tick
      else if (tick_i) cur_q <= cur_q + 1'b1;
      if (wr_bite_i) bite_q <= wdata_i;
      if (wr_ctrl_i) ren_q  <= wdata_i[CTRL_REN];
    end
  end

  assign cur_o     = cur_q;
  assign bite_o    = bite_q;
  assign rst_req_o = ren_q && (cur_q >= bite_q);

  generate
    if (HAS_BARK) begin : g_bark
      logic [DW-1:0] bark_q;
      logic          ien_q, sts_q;
      logic          bark_hit;
      assign bark_hit = ien_q && (cur_q >= bark_q);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bark_q <= '0;
          ien_q  <= 1'b0;
          sts_q  <= 1'b0;
        end else begin
          if (wr_bark_i) bark_q <= wdata_i;
          if (wr_ctrl_i) ien_q  <= wdata_i[CTRL_IEN];
          sts_q <= (sts_q && !(wr_ctrl_i && wdata_i[CTRL_STS])) || bark_hit;
        end
      end

      assign bark_o = bark_q;
      assign ctrl_o = {ren_q, sts_q, ien_q};
      assign irq_o  = sts_q && ien_q;

      AST_STS_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_q) |-> $past(ien_q && (cur_q >= bark_q)));  // R6
      AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_q && !(wr_ctrl_i && wdata_i[CTRL_STS])) |=> sts_q);  // R7
    end else begin : g_nobark
      assign bark_o = '0;
      assign ctrl_o = {ren_q, 2'b00};
      assign irq_o  = 1'b0;
    end
  endgenerate

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cur_i |=> (cur_q == $past(wdata_i)));  // R4
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cur_i) |=> (cur_q == $past(cur_q) + 1'b1));  // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cur_i) |=> $stable(cur_q));  // R3
endmodule

// File: rtl/wdt_rd_mux.sv
module wdt_rd_mux #(
  parameter int unsigned DW   = 32,
  parameter int unsigned N_CH = 3
) (
  input  logic                    rd_en_i,
  input  logic [1:0]              ch_i,
  input  logic [1:0]              sel_i,
  input  logic [N_CH-1:0][DW-1:0] cur_i,
  input  logic [N_CH-1:0][DW-1:0] bite_i,
  input  logic [N_CH-1:0][DW-1:0] bark_i,
  input  logic [N_CH-1:0][2:0]    ctrl_i,
  output logic [DW-1:0]           rdata_o
);
  import wdt_pkg::*;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && (32'(ch_i) < N_CH)) begin
      unique case (reg_sel_e'(sel_i))
        REG_CUR:  rdata_o = cur_i[ch_i];
        REG_BITE: rdata_o = bite_i[ch_i];
        REG_BARK: rdata_o = bark_i[ch_i];
        REG_CTRL: rdata_o = DW'(ctrl_i[ch_i]);
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_multi.sv
module wdt_multi #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              rst_recovery_o,
  output logic              rst_system_o,
  output logic              irq_o
);
  import wdt_pkg::*;

  localparam int unsigned NC = N_CH;

  logic       addr_ok, wr_go, rd_go;
  logic [1:0] ch, sel;

  assign addr_ok = (bus_addr_i[1:0] == 2'b00) && (bus_addr_i[ADDR_W-1:6] == '0);
  assign ch      = bus_addr_i[5:4];
  assign sel     = bus_addr_i[3:2];
  assign wr_go   = bus_valid_i && bus_write_i && addr_ok;
  assign rd_go   = bus_valid_i && !bus_write_i && addr_ok;

  logic [NC-1:0][DW-1:0] cur_all, bite_all, bark_all;
  logic [NC-1:0][2:0]    ctrl_all;
  logic [NC-1:0]         rst_req, irq_req;

  generate
    for (genvar c = 0; c < NC; c++) begin : g_ch
      logic hit;
      assign hit = wr_go && (ch == 2'(c));
      wdt_channel #(
        .DW       (DW),
        .HAS_BARK (c == 0)
      ) u_ch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .wr_cur_i  (hit && (sel == REG_CUR)),
        .wr_bite_i (hit && (sel == REG_BITE)),
        .wr_bark_i (hit && (sel == REG_BARK)),
        .wr_ctrl_i (hit && (sel == REG_CTRL)),
        .wdata_i   (bus_wdata_i),
        .cur_o     (cur_all[c]),
        .bite_o    (bite_all[c]),
        .bark_o    (bark_all[c]),
        .ctrl_o    (ctrl_all[c]),
        .rst_req_o (rst_req[c]),
        .irq_o     (irq_req[c])
      );
    end
  endgenerate

  wdt_rd_mux #(
    .DW   (DW),
    .N_CH (NC)
  ) u_rd_mux (
    .rd_en_i (rd_go),
    .ch_i    (ch),
    .sel_i   (sel),
    .cur_i   (cur_all),
    .bite_i  (bite_all),
    .bark_i  (bark_all),
    .ctrl_i  (ctrl_all),
    .rdata_o (bus_rdata_o)
  );

  assign rst_recovery_o = rst_req[0];
  assign rst_system_o   = |rst_req[NC-1:1];
  assign irq_o          = |irq_req;

  AST_SYS_RST_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_system_o |-> (ctrl_all[1][CTRL_REN] || ctrl_all[2][CTRL_REN]));  // R5
  AST_REC_RST_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_recovery_o |-> ctrl_all[0][CTRL_REN]);  // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_all[0][CTRL_IEN]);  // R6
endmodule

// File: tb/wdt_multi_tb.sv
`timescale 1ns/1ps
module wdt_multi_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_rec, rst_sys, irq;

  always #4 clk = ~clk;

  wdt_multi u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rst_recovery_o(rst_rec), .rst_system_o(rst_sys), .irq_o(irq)
  );

  int unsigned vecs = 0, errs = 0;
  logic [31:0] m_cur[3], m_bite[3], m_bark;
  logic        m_ren[3], m_ien, m_sts;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [1:0] c = a[5:4];
    if (a[1:0] != 0 || a[7:6] != 0 || c == 2'd3) return 0;
    case (a[3:2])
      2'd0: return m_cur[c];
      2'd1: return m_bite[c];
      2'd2: return (c == 0) ? m_bark : 32'd0;
      default: return (c == 0) ? {29'd0, m_ren[0], m_sts, m_ien} : {29'd0, m_ren[c], 2'b00};
    endcase
  endfunction

  function automatic logic exp_rec();
    return m_ren[0] && (m_cur[0] >= m_bite[0]);
  endfunction
  function automatic logic exp_sys();
    return (m_ren[1] && (m_cur[1] >= m_bite[1])) || (m_ren[2] && (m_cur[2] >= m_bite[2]));
  endfunction

  // One cycle: drive at negedge, check combinational outputs, advance the model.
  task automatic step(logic v, logic w, logic [7:0] a, logic [31:0] d, logic t, string rtag);
    logic ok, hit_set;
    logic [1:0] c;
    @(negedge clk);
    valid = v; write = w; addr = a; wdata = d; tick = t;
    #1;
    check("R5 recovery", 32'(rst_rec), 32'(exp_rec()));
    check("R5 system", 32'(rst_sys), 32'(exp_sys()));
    check("R6 irq", 32'(irq), 32'(m_sts && m_ien));
    if (v && !w) check(rtag, rdata, exp_rd(a));
    else check("R2 idle rdata", rdata, 32'd0);
    ok = (a[1:0] == 0) && (a[7:6] == 0) && (a[5:4] != 2'd3);
    c = a[5:4];
    hit_set = m_ien && (m_cur[0] >= m_bark);
    if (v && w && ok && c == 0 && a[3:2] == 2'd3 && d[1]) m_sts = 1'b0;
    if (hit_set) m_sts = 1'b1;
    for (int i = 0; i < 3; i++) if (t) m_cur[i] = m_cur[i] + 1;
    if (v && w && ok) begin
      case (a[3:2])
        2'd0: m_cur[c] = d;
        2'd1: m_bite[c] = d;
        2'd2: if (c == 0) m_bark = d;
        default: begin
          m_ren[c] = d[2];
          if (c == 0) m_ien = d[0];
        end
      endcase
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic t = 1'b0);
    step(1'b1, 1'b1, a, d, t, "R2");
  endtask
  task automatic rd(logic [7:0] a, string tag, logic t = 1'b0);
    step(1'b1, 1'b0, a, 32'd0, t, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", vecs, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] a;
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin m_cur[i] = 0; m_bite[i] = 0; m_ren[i] = 0; end
    m_bark = 0; m_ien = 0; m_sts = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 4; r++) rd(8'(c * 16 + r * 4), "R1 reset read");

    // R8: zero bite, zero counter, enable -> immediate request
    wr(8'h14, 0); wr(8'h10, 0); wr(8'h1C, 32'h4);
    @(negedge clk); #1 check("R8 immediate system reset", 32'(rst_sys), 32'd1);
    wr(8'h1C, 0);

    // R4: write collides with tick
    wr(8'h20, 32'h55, 1'b1);
    rd(8'h20, "R4 write wins over tick");
    // R3: wrap
    wr(8'h20, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 8'h00, 0, 1'b1, "R3");
    rd(8'h20, "R3 wrap to zero");
    step(1'b0, 1'b0, 8'h00, 0, 1'b0, "R3");
    rd(8'h20, "R3 hold without tick");

    // R6/R7: bark, sticky, W1C
    wr(8'h08, 32'd5); wr(8'h00, 32'd5); wr(8'h0C, 32'h1);
    step(1'b0, 1'b0, 8'h00, 0, 1'b0, "R6");
    rd(8'h0C, "R6 status set");
    wr(8'h00, 32'd0);
    rd(8'h0C, "R7 sticky after rewrite below bark");
    wr(8'h0C, 32'h1);
    rd(8'h0C, "R7 write zero leaves status");
    wr(8'h0C, 32'h3);
    rd(8'h0C, "R7 write one clears");
    wr(8'h00, 32'd9); wr(8'h0C, 32'h3);
    rd(8'h0C, "R6 set wins over clear");
    wr(8'h0C, 32'h2); wr(8'h0C, 32'h2);
    rd(8'h0C, "R7 clear with irq disabled");
    rd(8'h18, "R2 missing bark reads zero");
    rd(8'h30, "R2 unmapped channel");
    rd(8'h41, "R2 misaligned");

    // random
    for (int n = 0; n < 4000; n++) begin
      a = 8'({$urandom_range(0, 3), 2'(($urandom % 4))} << 2);
      if ($urandom % 16 == 0) a = 8'($urandom);
      case ($urandom % 4)
        0: d = $urandom;
        1: d = 32'hFFFF_FFFF;
        default: d = $urandom % 48;
      endcase
      if (a[3:2] == 2'd3) d = $urandom % 8;
      step(1'b1, 1'($urandom % 2), a, d, 1'($urandom % 2), "R2 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule